// File: doc/BRIEF.md
# USB Host Split-Transaction Channel Sequencer

This block runs one host channel that moves a transaction to a full- or low-speed device sitting behind a high-speed hub. The transaction is split into a start-split phase and a complete-split phase. Software configures the channel through register-style inputs: direction, transfer type (bulk/control or interrupt), microframe parity select and a complete-split flag. It then writes an enable. The channel asks an external arbiter for a slot. When the grant arrives it pushes exactly one request into the request queue and removes itself from arbitration. It then waits for link-layer status.

Each phase ends with a one-cycle halted pulse that sets a sticky status bit. Software answers the halt in one of two ways. It can set the complete-split flag and re-enable the channel, which returns the channel to arbitration. Or it can write a disable, which de-allocates the channel. OUT transfers read their packet from system memory before the start split is requested. IN transfers write the received packet to memory during the complete split, and only then raise the halt. Interrupt start splits are held back until the microframe parity matches the select input.

Top module: `split_chan_seq`

## Requirements
- R1: After reset the channel is idle. `arb_req`, `rq_push`, `dma_rd_req`, `dma_wr_req`, `halt_pulse` and `halt_sts` are all 0.
- R2: `rq_push` is high for exactly one cycle, namely the cycle after a cycle in which `arb_req` and `arb_gnt` were both high. With the push, `rq_periodic` is 1 for interrupt type and 0 for bulk/control, `rq_dir_in` is the direction, and `rq_csplit` is 1 for the complete-split phase.
- R3: After a push, `arb_req` stays 0 until the next enable write, even while `arb_gnt` stays high, and no second push occurs.
- R4: In the start-split phase, `halt_pulse` rises in the cycle after `link_tok_sent` is sampled for an IN channel, or after `link_hs_ack` is sampled for an OUT channel.
- R5: An enable write with `cfg_csplit`=1 from the halted state raises `arb_req` again. The channel waits for a fresh grant and then pushes a complete-split request.
- R6: In an IN complete split, `link_pkt_ok` raises `dma_wr_req` in the next cycle. `halt_pulse` does not fire until `dma_wr_done` is sampled, and fires in the cycle after that.
- R7: For an interrupt start split, `arb_req` stays 0 while bit 0 of `uframe` differs from `cfg_odd_sel`. It rises once the two match.
- R8: An OUT start split raises `dma_rd_req` first, with `arb_req` at 0. Arbitration begins only after `dma_rd_done`. An OUT complete split does not read memory, and halts on `link_hs_ack`.
- R9: `halt_pulse` lasts one cycle and sets `halt_sts`. `halt_clr`=1 clears `halt_sts`. When a halt and a clear meet in the same cycle, the status stays set.
- R10: A disable write (`sw_en_wr`=1, `sw_en_val`=0) returns the channel to idle, drops `arb_req` and clears `halt_sts`. An enable write with `cfg_csplit`=0 always starts a fresh start split.
- R11: With no grant, the channel keeps `arb_req` high indefinitely. There is no timeout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sw_en_wr | input | 1 | Software write strobe for the enable bit |
| sw_en_val | input | 1 | Written value: 1 enable, 0 disable/de-allocate |
| cfg_dir_in | input | 1 | 1 = IN transfer, 0 = OUT |
| cfg_intr | input | 1 | 1 = interrupt type, 0 = bulk/control |
| cfg_odd_sel | input | 1 | Required microframe parity for interrupt start split |
| cfg_csplit | input | 1 | Complete-split flag, sampled on enable write |
| uframe | input | UF_W | Microframe counter (low bits) |
| arb_req | output | 1 | Request to the arbiter |
| arb_gnt | input | 1 | Grant from the arbiter |
| rq_push | output | 1 | Push strobe into the request queue |
| rq_periodic | output | 1 | Queue select: 1 periodic, 0 non-periodic |
| rq_dir_in | output | 1 | Direction of the pushed request |
| rq_csplit | output | 1 | Pushed request is a complete split |
| link_tok_sent | input | 1 | Link layer: token transmitted |
| link_pkt_ok | input | 1 | Link layer: data packet received correctly |
| link_hs_ack | input | 1 | Link layer: successful handshake |
| dma_rd_req | output | 1 | Memory read request (OUT packet fetch) |
| dma_rd_done | input | 1 | Memory read finished |
| dma_wr_req | output | 1 | Memory write request (IN packet store) |
| dma_wr_done | input | 1 | Memory write finished |
| halt_clr | input | 1 | Write-one-to-clear for the halted status |
| halt_pulse | output | 1 | One-cycle channel-halted interrupt |
| halt_sts | output | 1 | Sticky halted status |

## Verification
Two events can land on the same clock edge: a new halt, raised by the end of a memory write, and a software write-one-to-clear of the sticky status. The bench drives `halt_clr` in exactly the cycle in which `dma_wr_done` is sampled, then checks that the pulse appears and that the status remains set. It then checks that a later clear on its own removes the status. A second overlap comes from holding `arb_gnt` high for several cycles across a push. The scoreboard must then see exactly one push, and `arb_req` must fall while the grant is still high.

// File: rtl/split_pkg.sv
package split_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_FETCH = 3'd1,
    ST_ARB   = 3'd2,
    ST_WAIT  = 3'd3,
    ST_DMAWR = 3'd4,
    ST_HALT  = 3'd5
  } chan_st_t;

  typedef struct packed {
    logic dir_in;
    logic intr;
    logic odd;
    logic csplit;
  } chan_cfg_t;

endpackage

// File: rtl/split_uframe_gate.sv
module split_uframe_gate #(
  parameter int UF_W = 3
) (
  input  logic [UF_W-1:0] uframe,
  input  logic            odd_sel,
  input  logic            intr,
  input  logic            csplit,
  output logic            go
);
  logic parity;

  generate
    if (UF_W > 1) begin : g_wide
      assign parity = uframe[0];
    end else begin : g_narrow
      assign parity = uframe;
    end
  endgenerate

  // Only interrupt start splits are tied to microframe parity.
  assign go = !intr || csplit || (parity == odd_sel);
endmodule

// File: rtl/split_arb_port.sv
module split_arb_port
  import split_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      want,
  input  logic      rearm,
  input  chan_cfg_t cfg,
  input  logic      arb_gnt,
  output logic      arb_req,
  output logic      won,
  output logic      rq_push,
  output logic      rq_periodic,
  output logic      rq_dir_in,
  output logic      rq_csplit
);
  logic mask_q;

  assign arb_req = want && !mask_q;
  assign won     = arb_req && arb_gnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q <= 1'b0;
    end else if (rearm) begin
      mask_q <= 1'b0;
    end else if (won) begin
      mask_q <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rq_push     <= 1'b0;
      rq_periodic <= 1'b0;
      rq_dir_in   <= 1'b0;
      rq_csplit   <= 1'b0;
    end else begin
      rq_push <= won;
      if (won) begin
        rq_periodic <= cfg.intr;
        rq_dir_in   <= cfg.dir_in;
        rq_csplit   <= cfg.csplit;
      end
    end
  end
endmodule

// File: rtl/split_halt_ctrl.sv
module split_halt_ctrl (
  input  logic clk,
  input  logic rst,
  input  logic halt_set,
  input  logic dealloc,
  input  logic halt_clr,
  output logic halt_pulse,
  output logic halt_sts
);
  always_ff @(posedge clk) begin
    if (rst) begin
      halt_pulse <= 1'b0;
      halt_sts   <= 1'b0;
    end else begin
      halt_pulse <= halt_set && !dealloc;
      if (dealloc) begin
        halt_sts <= 1'b0;
      end else if (halt_set) begin
        halt_sts <= 1'b1;
      end else if (halt_clr) begin
        halt_sts <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/split_seq_fsm.sv
module split_seq_fsm
  import split_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      en_start,
  input  logic      en_stop,
  input  chan_cfg_t cfg_in,
  input  logic      gate_go,
  input  logic      won,
  input  logic      link_tok_sent,
  input  logic      link_pkt_ok,
  input  logic      link_hs_ack,
  input  logic      dma_rd_done,
  input  logic      dma_wr_done,
  output chan_cfg_t cfg_q,
  output chan_st_t  state,
  output logic      want,
  output logic      rearm,
  output logic      halt_set,
  output logic      dma_rd_req,
  output logic      dma_wr_req
);
  chan_st_t nxt;
  logic     accept;

  assign accept = en_start && (state == ST_IDLE || state == ST_HALT);
  assign rearm  = accept || en_stop;
  assign want   = (state == ST_ARB) && gate_go;

  always_comb begin
    nxt      = state;
    halt_set = 1'b0;
    case (state)
      ST_IDLE, ST_HALT: begin
        if (accept) begin
          nxt = (!cfg_in.dir_in && !cfg_in.csplit) ? ST_FETCH : ST_ARB;
        end
      end
      ST_FETCH: if (dma_rd_done) nxt = ST_ARB;
      ST_ARB:   if (won) nxt = ST_WAIT;
      ST_WAIT: begin
        if (!cfg_q.csplit) begin
          if (cfg_q.dir_in ? link_tok_sent : link_hs_ack) begin
            nxt      = ST_HALT;
            halt_set = 1'b1;
          end
        end else if (cfg_q.dir_in) begin
          if (link_pkt_ok) nxt = ST_DMAWR;
        end else if (link_hs_ack) begin
          nxt      = ST_HALT;
          halt_set = 1'b1;
        end
      end
      ST_DMAWR: begin
        if (dma_wr_done) begin
          nxt      = ST_HALT;
          halt_set = 1'b1;
        end
      end
      default: nxt = ST_IDLE;
    endcase
    if (en_stop) begin
      nxt = ST_IDLE;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      cfg_q      <= '0;
      dma_rd_req <= 1'b0;
      dma_wr_req <= 1'b0;
    end else begin
      state      <= nxt;
      dma_rd_req <= (nxt == ST_FETCH);
      dma_wr_req <= (nxt == ST_DMAWR);
      if (accept) begin
        cfg_q <= cfg_in;
      end
    end
  end
endmodule

// File: rtl/split_chan_seq.sv
module split_chan_seq
  import split_pkg::*;
#(
  parameter int UF_W = 3
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            sw_en_wr,
  input  logic            sw_en_val,
  input  logic            cfg_dir_in,
  input  logic            cfg_intr,
  input  logic            cfg_odd_sel,
  input  logic            cfg_csplit,
  input  logic [UF_W-1:0] uframe,
  output logic            arb_req,
  input  logic            arb_gnt,
  output logic            rq_push,
  output logic            rq_periodic,
  output logic            rq_dir_in,
  output logic            rq_csplit,
  input  logic            link_tok_sent,
  input  logic            link_pkt_ok,
  input  logic            link_hs_ack,
  output logic            dma_rd_req,
  input  logic            dma_rd_done,
  output logic            dma_wr_req,
  input  logic            dma_wr_done,
  input  logic            halt_clr,
  output logic            halt_pulse,
  output logic            halt_sts
);
  chan_cfg_t cfg_in, cfg_q;
  chan_st_t  state;
  logic      en_start, en_stop, gate_go, want, won, rearm, halt_set;

  assign en_start = sw_en_wr && sw_en_val;
  assign en_stop  = sw_en_wr && !sw_en_val;
  assign cfg_in   = '{dir_in: cfg_dir_in, intr: cfg_intr, odd: cfg_odd_sel, csplit: cfg_csplit};

  split_uframe_gate #(.UF_W(UF_W)) u_gate (
    .uframe (uframe),
    .odd_sel(cfg_q.odd),
    .intr   (cfg_q.intr),
    .csplit (cfg_q.csplit),
    .go     (gate_go)
  );

  split_seq_fsm u_fsm (
    .clk          (clk),
    .rst          (rst),
    .en_start     (en_start),
    .en_stop      (en_stop),
    .cfg_in       (cfg_in),
    .gate_go      (gate_go),
    .won          (won),
    .link_tok_sent(link_tok_sent),
    .link_pkt_ok  (link_pkt_ok),
    .link_hs_ack  (link_hs_ack),
    .dma_rd_done  (dma_rd_done),
    .dma_wr_done  (dma_wr_done),
    .cfg_q        (cfg_q),
    .state        (state),
    .want         (want),
    .rearm        (rearm),
    .halt_set     (halt_set),
    .dma_rd_req   (dma_rd_req),
    .dma_wr_req   (dma_wr_req)
  );

  split_arb_port u_arb (
    .clk        (clk),
    .rst        (rst),
    .want       (want),
    .rearm      (rearm),
    .cfg        (cfg_q),
    .arb_gnt    (arb_gnt),
    .arb_req    (arb_req),
    .won        (won),
    .rq_push    (rq_push),
    .rq_periodic(rq_periodic),
    .rq_dir_in  (rq_dir_in),
    .rq_csplit  (rq_csplit)
  );

  split_halt_ctrl u_halt (
    .clk       (clk),
    .rst       (rst),
    .halt_set  (halt_set),
    .dealloc   (en_stop),
    .halt_clr  (halt_clr),
    .halt_pulse(halt_pulse),
    .halt_sts  (halt_sts)
  );
endmodule

// File: rtl/split_chan_seq_chk.sv
module split_chan_seq_chk #(
  parameter int UF_W = 3
) (
  input logic            clk,
  input logic            rst,
  input logic            sw_en_wr,
  input logic            sw_en_val,
  input logic [UF_W-1:0] uframe,
  input logic            arb_req,
  input logic            arb_gnt,
  input logic            rq_push,
  input logic            dma_rd_req,
  input logic            dma_wr_req,
  input logic            halt_pulse,
  input logic            halt_sts,
  input logic            lat_intr,
  input logic            lat_odd,
  input logic            lat_cs
);
  assert_push_after_grant_R2: assert property (@(posedge clk) disable iff (rst)
    rq_push |-> $past(arb_req && arb_gnt));

  assert_push_single_R2: assert property (@(posedge clk) disable iff (rst)
    rq_push |=> !rq_push);

  assert_mask_after_push_R3: assert property (@(posedge clk) disable iff (rst)
    rq_push && !$past(sw_en_wr) |-> !arb_req);

  assert_halt_one_cycle_R9: assert property (@(posedge clk) disable iff (rst)
    halt_pulse |=> !halt_pulse);

  assert_halt_sets_status_R9: assert property (@(posedge clk) disable iff (rst)
    halt_pulse |-> halt_sts);

  assert_parity_hold_R7: assert property (@(posedge clk) disable iff (rst)
    arb_req && lat_intr && !lat_cs |-> uframe[0] == lat_odd);

  assert_fetch_before_arb_R8: assert property (@(posedge clk) disable iff (rst)
    dma_rd_req |-> !arb_req);

  assert_dma_exclusive_R6: assert property (@(posedge clk) disable iff (rst)
    !(dma_rd_req && dma_wr_req));

  assert_dealloc_clears_R10: assert property (@(posedge clk) disable iff (rst)
    sw_en_wr && !sw_en_val |=> !halt_sts && !arb_req && !halt_pulse);
endmodule

bind split_chan_seq split_chan_seq_chk #(.UF_W(UF_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .sw_en_wr  (sw_en_wr),
  .sw_en_val (sw_en_val),
  .uframe    (uframe),
  .arb_req   (arb_req),
  .arb_gnt   (arb_gnt),
  .rq_push   (rq_push),
  .dma_rd_req(dma_rd_req),
  .dma_wr_req(dma_wr_req),
  .halt_pulse(halt_pulse),
  .halt_sts  (halt_sts),
  .lat_intr  (cfg_q.intr),
  .lat_odd   (cfg_q.odd),
  .lat_cs    (cfg_q.csplit)
);

// File: tb/split_chan_seq_bench.sv
module split_chan_seq_bench;
  localparam int UF_W = 3;
  localparam int HALT_ITEM = 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sw_en_wr = 0, sw_en_val = 0, cfg_dir_in = 0, cfg_intr = 0, cfg_odd_sel = 0, cfg_csplit = 0;
  logic [UF_W-1:0] uframe = '0;
  logic arb_gnt = 0, link_tok_sent = 0, link_pkt_ok = 0, link_hs_ack = 0;
  logic dma_rd_done = 0, dma_wr_done = 0, halt_clr = 0;
  logic arb_req, rq_push, rq_periodic, rq_dir_in, rq_csplit;
  logic dma_rd_req, dma_wr_req, halt_pulse, halt_sts;

  int n_cmp = 0;
  int n_bad = 0;
  int exp_q[$];
  bit finished = 0;

  always #2 clk = ~clk;

  split_chan_seq #(.UF_W(UF_W)) u_split_chan_seq (.*);

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cmp(input string req, input int act, input int exp);
    check(act == exp, req, act, exp);
  endtask

  // push item code: 8 + csplit*4 + periodic*2 + dir_in ; halt item code: 1
  task automatic expect_push(input bit cs, input bit per, input bit din);
    exp_q.push_back(8 + cs * 4 + per * 2 + din);
  endtask

  task automatic expect_halt();
    exp_q.push_back(HALT_ITEM);
  endtask

  // monitor: compares every produced event against the expected queue (R2, R4, R6, R9)
  always @(negedge clk) begin
    if (!rst) begin
      if (rq_push) begin
        if (exp_q.size() == 0) cmp("R2 unexpected push", 8 + rq_csplit * 4 + rq_periodic * 2 + rq_dir_in, 0);
        else cmp("R2 push kind", 8 + rq_csplit * 4 + rq_periodic * 2 + rq_dir_in, exp_q.pop_front());
      end
      if (halt_pulse) begin
        if (exp_q.size() == 0) cmp("R4 unexpected halt", HALT_ITEM, 0);
        else cmp("R4 halt event", HALT_ITEM, exp_q.pop_front());
      end
    end
  end

  task automatic step(input int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic write_en(input bit val, input bit din, input bit intr, input bit odd, input bit cs);
    sw_en_wr = 1; sw_en_val = val; cfg_dir_in = din; cfg_intr = intr; cfg_odd_sel = odd; cfg_csplit = cs;
    step();
    sw_en_wr = 0;
  endtask

  task automatic pulse_tok();  link_tok_sent = 1; step(); link_tok_sent = 0; endtask
  task automatic pulse_ack();  link_hs_ack = 1;   step(); link_hs_ack = 0;   endtask
  task automatic pulse_pkt();  link_pkt_ok = 1;   step(); link_pkt_ok = 0;   endtask

  task automatic grant_once();
    arb_gnt = 1; step(); arb_gnt = 0;
  endtask

  task automatic finish_run();
    step(2);
    cmp("R2 scoreboard drained", exp_q.size(), 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    step(3);
    rst = 0;
    step();
    // R1 reset state
    cmp("R1 arb_req", arb_req, 0);
    cmp("R1 rq_push", rq_push, 0);
    cmp("R1 dma", dma_rd_req | dma_wr_req, 0);
    cmp("R1 halt_sts", halt_sts, 0);

    // bulk IN start split
    write_en(1, 1, 0, 0, 0);
    cmp("R2 arb_req while waiting", arb_req, 1);
    expect_push(0, 0, 1);
    arb_gnt = 1; step();            // grant sampled
    cmp("R3 req drops after grant", arb_req, 0);
    step(3);                        // grant still high: no second push
    cmp("R3 masked with grant held", arb_req, 0);
    arb_gnt = 0;
    expect_halt();
    pulse_tok();
    cmp("R4 halt status after token", halt_sts, 1);
    step();
    cmp("R9 halt is one cycle", halt_pulse, 0);
    halt_clr = 1; step(); halt_clr = 0;
    cmp("R9 W1C clears status", halt_sts, 0);

    // bulk IN complete split
    write_en(1, 1, 0, 0, 1);
    cmp("R5 re-enable rejoins arbitration", arb_req, 1);
    step(4);
    cmp("R5 waits for fresh grant", arb_req, 1);
    expect_push(1, 0, 1);
    grant_once();
    step();
    pulse_pkt();
    cmp("R6 memory write requested", dma_wr_req, 1);
    step(3);
    cmp("R6 no halt before write done", halt_sts, 0);
    // halt and clear in the same cycle: status stays set (R9)
    expect_halt();
    dma_wr_done = 1; halt_clr = 1; step(); dma_wr_done = 0; halt_clr = 0;
    cmp("R6 halt after write done", halt_pulse, 1);
    cmp("R9 set beats clear", halt_sts, 1);
    step();
    cmp("R9 status sticky", halt_sts, 1);
    write_en(0, 0, 0, 0, 0);
    cmp("R10 disable clears status", halt_sts, 0);
    cmp("R10 disable idles", arb_req, 0);

    // interrupt IN start split, odd parity required
    uframe = 3'd2;
    write_en(1, 1, 1, 1, 0);
    step(3);
    cmp("R7 held on even microframe", arb_req, 0);
    uframe = 3'd3;
    step();
    cmp("R7 request on odd microframe", arb_req, 1);
    expect_push(0, 1, 1);
    grant_once();
    expect_halt();
    pulse_tok();
    // fresh start from halted with csplit clear (R10)
    uframe = 3'd4;
    write_en(1, 1, 1, 0, 0);
    cmp("R10 fresh start re-requests", arb_req, 1);
    expect_push(0, 1, 1);
    grant_once();
    write_en(0, 0, 0, 0, 0);

    // interrupt OUT split
    uframe = 3'd1;
    write_en(1, 0, 1, 1, 0);
    cmp("R8 fetch first", dma_rd_req, 1);
    cmp("R8 no arbitration during fetch", arb_req, 0);
    step(2);
    dma_rd_done = 1; step(); dma_rd_done = 0;
    cmp("R8 arbitration after fetch", arb_req, 1);
    expect_push(0, 1, 0);
    grant_once();
    expect_halt();
    pulse_ack();
    write_en(1, 0, 1, 1, 1);
    cmp("R8 no fetch in complete split", dma_rd_req, 0);
    expect_push(1, 1, 0);
    grant_once();
    expect_halt();
    pulse_ack();
    cmp("R8 complete split halts", halt_sts, 1);
    write_en(0, 0, 0, 0, 0);

    // no grant ever: waits indefinitely (R11)
    write_en(1, 1, 0, 0, 0);
    step(600);
    cmp("R11 still requesting", arb_req, 1);
    write_en(0, 0, 0, 0, 0);
    cmp("R10 disable drops request", arb_req, 0);

    finished = 1;
    finish_run();
  end
endmodule